// File: doc/BRIEF.md
# Timer-Clocked Synchronous Serial Port

This block is a byte-wide synchronous shift port whose direction is chosen by software. In transmit mode it acts as bus master. It drives a serial clock pin and a serial data pin. The clock edges come from the underflows of a reloadable 16-bit down-counter, so the bit rate is set by the value loaded into that counter rather than by a fixed divider. In receive mode the port is a slave. It samples the data pin on rising edges of an external serial clock and collects eight bits into the data register.

Bytes travel most-significant bit first. A new bit appears when the serial clock falls, and the receiver takes it when the clock rises. When a byte finishes in either direction, a serial-done flag is raised in an interrupt status register. That flag drives the interrupt line when its mask bit is set, and reading the status register clears it. A byte written while a transfer is in flight waits in a one-deep holding slot. It goes out right after the current byte, with no gap in the bit timing.

Software reaches the port through a small register bus. Offset 0 is the data register, offset 1 the low byte of the timer reload value, offset 2 the high byte, offset 3 the control register and offset 4 the interrupt status/mask register.

Top module: `ssp_port`

## Requirements
- R1: In transmit mode the eight bits of a byte appear on `sp_out` MSB first. `sp_out` changes only when `cnt_out` falls, so each bit is stable across the following rising edge of `cnt_out`.
- R2: While the timer runs, it counts down from the reload value and underflows once every reload+1 cycles, reloading itself on each underflow. `cnt_out` toggles only on an underflow, so one bit lasts 2*(reload+1) cycles. A reload of 0 gives the fastest rate of one bit per two clock cycles.
- R3: Control bit 6 selects the direction: 1 is transmit, 0 is receive. Bit 0 runs the timer. 0xC1 means transmit with the timer running, and 0x81 means receive with the timer running. `sp_drive` and `cnt_drive` are high only in transmit mode. `cnt_out` idles high whenever no byte is being shifted out.
- R4: When a byte completes in either mode, bit 3 (value 0x08) of the status register is set. `irq` is high while that flag is set and bit 3 of the mask is set. Status bit 7 mirrors `irq`. Writing offset 4 loads the mask.
- R5: A read of the status register returns the flag, then clears it. A second read returns 0 and `irq` drops.
- R6: In receive mode `cnt_in` and `sp_in` pass through a synchronizer. A bit is shifted in only on a rising edge of the synchronized `cnt_in`, and falling edges are ignored. After the eighth bit the assembled byte, MSB first, can be read at offset 0 and the flag of R4 is set.
- R7: A data write in transmit mode while a byte is being shifted is held. That byte starts at the underflow after the last rising edge of the current byte, so the bit period stays constant across the boundary.
- R8: After reset the data, control and status registers read 0, `cnt_out` is 1, `sp_out` is 0, `irq` is 0 and both drive enables are 0.
- R9: In transmit mode with the timer stopped (control 0x40), a data write produces no clock edge. The byte stays pending and is sent once the timer is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears the status flag on offset 4) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Serial-done interrupt, flag AND mask |
| sp_in | input | 1 | Serial data input (receive mode) |
| sp_out | output | 1 | Serial data output (transmit mode) |
| sp_drive | output | 1 | Output enable for the serial data pin |
| cnt_in | input | 1 | External serial clock (receive mode) |
| cnt_out | output | 1 | Generated serial clock (transmit mode) |
| cnt_drive | output | 1 | Output enable for the serial clock pin |

## Verification
The bench builds the port with the default 16-bit timer and with a three-stage input synchronizer instead of the default two. This shows that the receive path depends only on edge order and not on a fixed latency. Reload values of 0, 1, 2 and 3 bring the fastest rate and several slower bit periods within reach. A stopped-timer write and a back-to-back pair of writes probe the pending-byte slot at both of its edges.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 3;
    localparam int IRQ_SER_BIT = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_TLO  = 3'd1,
        REG_THI  = 3'd2,
        REG_CTRL = 3'd3,
        REG_IRQ  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic       aux;      // bit 7: stored, no function here
        logic       dir_out;  // bit 6: 1 = transmit
        logic [4:0] spare;    // bits 5..1: stored only
        logic       run;      // bit 0: timer running
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] status_byte(input logic any, input logic ser);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[BYTE_W-1]    = any;
        s[IRQ_SER_BIT] = ser;
        return s;
    endfunction

endpackage

// File: rtl/ssp_timer.sv
module ssp_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         uf
);
    assign uf = run && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (!run || count == '0) begin
            count <= reload;
        end else begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r;

    for (genvar i = 0; i < STAGES; i++) begin : g_st
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) r[i] <= RST_VAL;
                else     r[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) r[i] <= RST_VAL;
                else     r[i] <= r[i-1];
            end
        end
    end

    assign q = r[STAGES-1];
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          uf,
    input  logic          have_byte,
    input  logic [BW-1:0] byte_in,
    output logic          take,
    output logic          done,
    output logic          busy,
    output logic          sck,
    output logic          sdo
);
    localparam int CW = $clog2(BW);
    localparam logic [CW-1:0] LAST = CW'(BW - 1);

    logic [BW-1:0] sh;
    logic [CW-1:0] nrise;

    assign take = en && uf && !busy && have_byte;
    assign sdo  = sh[BW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            busy  <= 1'b0;
            sck   <= 1'b1;
            nrise <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                busy  <= 1'b0;
                sck   <= 1'b1;
                nrise <= '0;
            end else if (uf) begin
                if (!busy) begin
                    if (have_byte) begin
                        sh    <= byte_in;
                        busy  <= 1'b1;
                        sck   <= 1'b0;
                        nrise <= '0;
                    end
                end else if (!sck) begin
                    sck <= 1'b1;
                    if (nrise == LAST) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        nrise <= nrise + 1'b1;
                    end
                end else begin
                    sck <= 1'b0;
                    sh  <= {sh[BW-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
    parameter int BW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          sck_in,
    input  logic          sdi,
    output logic          done,
    output logic [BW-1:0] byte_out
);
    localparam int CW = $clog2(BW);
    localparam logic [CW-1:0] LAST = CW'(BW - 1);

    logic          sck_s, sdi_s, sck_prev, rise;
    logic [BW-1:0] sh;
    logic [CW-1:0] nbits;

    ssp_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync_sck (
        .clk(clk), .rst(rst), .d(sck_in), .q(sck_s)
    );
    ssp_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst(rst), .d(sdi), .q(sdi_s)
    );

    assign rise = sck_s && !sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b1;
            sh       <= '0;
            nbits    <= '0;
            done     <= 1'b0;
            byte_out <= '0;
        end else begin
            sck_prev <= sck_s;
            done     <= 1'b0;
            if (!en) begin
                nbits <= '0;
            end else if (rise) begin
                sh <= {sh[BW-2:0], sdi_s};
                if (nbits == LAST) begin
                    nbits    <= '0;
                    done     <= 1'b1;
                    byte_out <= {sh[BW-2:0], sdi_s};
                end else begin
                    nbits <= nbits + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
#(
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq,
    input  logic        sp_in,
    output logic        sp_out,
    output logic        sp_drive,
    input  logic        cnt_in,
    output logic        cnt_out,
    output logic        cnt_drive
);
    localparam int HI_W = TMR_W - BYTE_W;

    reg_sel_e           sel;
    ctrl_t              ctrl_q;
    logic [TMR_W-1:0]   latch_q;
    logic [TMR_W-1:0]   tmr_count;
    logic               tmr_uf;
    logic [BYTE_W-1:0]  data_q;
    logic [BYTE_W-1:0]  mask_q;
    logic               pend_q;
    logic               flag_q;
    logic               tx_take, tx_done, tx_busy;
    logic               rx_done;
    logic [BYTE_W-1:0]  rx_byte;
    logic               byte_done;
    logic               ctrl_wr, irq_rd, data_wr;

    assign sel       = reg_sel_e'(bus_addr);
    assign ctrl_wr   = bus_wr && sel == REG_CTRL;
    assign data_wr   = bus_wr && sel == REG_DATA;
    assign irq_rd    = bus_rd && sel == REG_IRQ;
    assign byte_done = tx_done || rx_done;

    ssp_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .reload(latch_q),
        .count(tmr_count), .uf(tmr_uf)
    );

    ssp_tx #(.BW(BYTE_W)) u_tx (
        .clk(clk), .rst(rst), .en(ctrl_q.dir_out), .uf(tmr_uf),
        .have_byte(pend_q), .byte_in(data_q), .take(tx_take),
        .done(tx_done), .busy(tx_busy), .sck(cnt_out), .sdo(sp_out)
    );

    ssp_rx #(.BW(BYTE_W), .STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst(rst), .en(!ctrl_q.dir_out), .sck_in(cnt_in),
        .sdi(sp_in), .done(rx_done), .byte_out(rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            latch_q <= '1;
            data_q  <= '0;
            mask_q  <= '0;
            pend_q  <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata);
            if (bus_wr && sel == REG_TLO) latch_q[BYTE_W-1:0] <= bus_wdata;
            if (bus_wr && sel == REG_THI) latch_q[TMR_W-1:BYTE_W] <= bus_wdata[HI_W-1:0];
            if (bus_wr && sel == REG_IRQ) mask_q <= bus_wdata;

            if (rx_done) data_q <= rx_byte;
            if (data_wr) data_q <= bus_wdata;

            if (data_wr && ctrl_q.dir_out) pend_q <= 1'b1;
            else if (tx_take || !ctrl_q.dir_out) pend_q <= 1'b0;

            if (byte_done)   flag_q <= 1'b1;
            else if (irq_rd) flag_q <= 1'b0;
        end
    end

    assign irq       = flag_q && mask_q[IRQ_SER_BIT];
    assign sp_drive  = ctrl_q.dir_out;
    assign cnt_drive = ctrl_q.dir_out;

    always_comb begin
        case (sel)
            REG_DATA: bus_rdata = data_q;
            REG_TLO:  bus_rdata = tmr_count[BYTE_W-1:0];
            REG_THI:  bus_rdata = 8'(tmr_count[TMR_W-1:BYTE_W]);
            REG_CTRL: bus_rdata = ctrl_q;
            REG_IRQ:  bus_rdata = status_byte(irq, flag_q);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk (
    input logic clk,
    input logic rst,
    input logic dir_out,
    input logic tmr_uf,
    input logic cnt_out,
    input logic sp_out,
    input logic flag,
    input logic irq_rd,
    input logic byte_done
);
    AST_CLOCK_IDLE_IN_RX: assert property (@(posedge clk) disable iff (rst)
        (!dir_out && $past(!dir_out)) |-> cnt_out);                                     // R3

    AST_CLOCK_MOVES_ON_UF: assert property (@(posedge clk) disable iff (rst)
        (dir_out && $past(dir_out) && !$stable(cnt_out)) |-> $past(tmr_uf));            // R2

    AST_DATA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (dir_out && $past(dir_out) && !$stable(sp_out)) |-> $fell(cnt_out));            // R1

    AST_FLAG_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(byte_done));                                              // R4

    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_rd) && !$past(byte_done)) |-> !flag);                                // R5
endmodule

bind ssp_port ssp_port_chk u_chk (
    .clk(clk), .rst(rst), .dir_out(ctrl_q.dir_out), .tmr_uf(tmr_uf),
    .cnt_out(cnt_out), .sp_out(sp_out), .flag(flag_q),
    .irq_rd(irq_rd), .byte_done(byte_done)
);

// File: tb/ssp_port_bench.sv
module ssp_port_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, sp_in, sp_out, sp_drive, cnt_in, cnt_out, cnt_drive;

    int total = 0;
    int bad   = 0;

    // edge monitor
    logic        mon_clr = 1'b0;
    logic        cnt_prev = 1'b1;
    logic [15:0] cap = '0;
    int          nrise = 0;
    int          cyc = 0;
    int          last_cyc = 0;
    bit          have_last = 0;
    int          pmin = 1000000;
    int          pmax = 0;

    initial begin
        sp_in  = 1'b0;
        cnt_in = 1'b1;
    end

    always #(CLK_PERIOD/2) clk = ~clk;

    ssp_port #(.TMR_W(16), .SYNC_STAGES(3)) u_ssp_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sp_in(sp_in), .sp_out(sp_out), .sp_drive(sp_drive),
        .cnt_in(cnt_in), .cnt_out(cnt_out), .cnt_drive(cnt_drive)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_clr) begin
            nrise = 0; cap = '0; have_last = 0; pmin = 1000000; pmax = 0;
        end else if (cnt_out && !cnt_prev && sp_drive) begin
            cap   = {cap[14:0], sp_out};
            nrise = nrise + 1;
            if (have_last) begin
                if (cyc - last_cyc < pmin) pmin = cyc - last_cyc;
                if (cyc - last_cyc > pmax) pmax = cyc - last_cyc;
            end
            last_cyc  = cyc;
            have_last = 1;
        end
        cnt_prev = cnt_out;
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        @(negedge clk);
        #1 mon_clr = 1'b0;
    endtask

    task automatic wait_rises(input int n, input string req);
        int guard = 0;
        while (nrise < n && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(nrise >= n, req, nrise, n);
    endtask

    task automatic set_reload(input logic [15:0] v);
        bus_write(3'd1, v[7:0]);
        bus_write(3'd2, v[15:8]);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(3'd0, v); check(v == 8'h00, "R8 data", v, 0);
        bus_read(3'd3, v); check(v == 8'h00, "R8 ctrl", v, 0);
        bus_read(3'd4, v); check(v == 8'h00, "R8 status", v, 0);
        check(cnt_out == 1'b1 && sp_out == 1'b0 && irq == 1'b0, "R8 pins",
              {cnt_out, sp_out, irq}, 3'b100);
        check(sp_drive == 1'b0 && cnt_drive == 1'b0, "R8 drives", {sp_drive, cnt_drive}, 0);
    endtask

    task automatic t_tx_basic();
        logic [7:0] v;
        set_reload(16'd3);
        bus_write(3'd4, 8'h08);
        bus_write(3'd3, 8'hC1);
        check(sp_drive && cnt_drive && cnt_out, "R3 tx drives idle high",
              {sp_drive, cnt_drive, cnt_out}, 3'b111);
        clear_mon();
        bus_write(3'd0, 8'h56);
        wait_rises(8, "R1 rises");
        check(cap[7:0] == 8'h56, "R1 msb first", cap[7:0], 8'h56);
        check(pmin == 8 && pmax == 8, "R2 bit period reload 3", pmax, 8);
        repeat (40) @(negedge clk);
        check(nrise == 8, "R1 exactly eight bits", nrise, 8);
        check(cnt_out == 1'b1, "R3 idle high after byte", cnt_out, 1);
        check(irq == 1'b1, "R4 irq raised", irq, 1);
        bus_read(3'd4, v); check(v == 8'h88, "R4 status after tx", v, 8'h88);
        bus_read(3'd4, v); check(v == 8'h00, "R5 cleared by read", v, 0);
        check(irq == 1'b0, "R5 irq dropped", irq, 0);
    endtask

    task automatic t_tx_fast();
        logic [7:0] v;
        set_reload(16'd0);
        clear_mon();
        bus_write(3'd0, 8'hA5);
        wait_rises(8, "R2 rises fast");
        check(cap[7:0] == 8'hA5, "R1 fast byte", cap[7:0], 8'hA5);
        check(pmin == 2 && pmax == 2, "R2 two cycles per bit", pmax, 2);
        repeat (6) @(negedge clk);
        bus_read(3'd4, v);
    endtask

    task automatic t_stopped();
        logic [7:0] v;
        set_reload(16'd1);
        bus_write(3'd3, 8'h40);
        clear_mon();
        bus_write(3'd0, 8'h3C);
        repeat (60) @(negedge clk);
        check(nrise == 0 && cnt_out == 1'b1, "R9 no clock while stopped", nrise, 0);
        bus_write(3'd3, 8'hC1);
        wait_rises(8, "R9 rises after start");
        check(cap[7:0] == 8'h3C, "R9 pending byte sent", cap[7:0], 8'h3C);
        check(pmax == 4, "R2 bit period reload 1", pmax, 4);
        repeat (10) @(negedge clk);
        bus_read(3'd4, v);
    endtask

    task automatic t_back_to_back();
        logic [7:0] v;
        set_reload(16'd2);
        clear_mon();
        bus_write(3'd0, 8'h81);
        repeat (10) @(negedge clk);
        bus_write(3'd0, 8'h7E);
        wait_rises(16, "R7 rises");
        check(cap == 16'h817E, "R7 both bytes in order", cap, 16'h817E);
        check(pmin == 6 && pmax == 6, "R7 no gap between bytes", pmax, 6);
        repeat (20) @(negedge clk);
        check(nrise == 16, "R7 sixteen bits", nrise, 16);
        bus_read(3'd4, v);
    endtask

    task automatic t_masked();
        logic [7:0] v;
        bus_write(3'd4, 8'h00);
        clear_mon();
        bus_write(3'd0, 8'h11);
        wait_rises(8, "R4 masked rises");
        repeat (20) @(negedge clk);
        check(irq == 1'b0, "R4 masked irq low", irq, 0);
        bus_read(3'd4, v); check(v == 8'h08, "R4 masked status", v, 8'h08);
    endtask

    task automatic t_rx();
        logic [7:0] v;
        logic [7:0] pat;
        pat = 8'hC3;
        bus_write(3'd4, 8'h08);
        bus_write(3'd3, 8'h81);
        repeat (3) @(negedge clk);
        check(!sp_drive && !cnt_drive && cnt_out, "R3 rx releases pins",
              {sp_drive, cnt_drive, cnt_out}, 3'b001);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            cnt_in = 1'b0;
            sp_in  = pat[i];
            repeat (5) @(negedge clk);
            cnt_in = 1'b1;
            repeat (5) @(negedge clk);
            if (i == 1) begin
                bus_read(3'd4, v);
                check(v == 8'h00, "R6 no flag before eighth bit", v, 0);
            end
        end
        repeat (8) @(negedge clk);
        bus_read(3'd0, v); check(v == 8'hC3, "R6 rx byte", v, 8'hC3);
        check(irq == 1'b1, "R6 irq after rx", irq, 1);
        bus_read(3'd4, v); check(v == 8'h88, "R6 status after rx", v, 8'h88);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tx_basic();
        t_tx_fast();
        t_stopped();
        t_back_to_back();
        t_masked();
        t_rx();
        summary();
        $finish;
    end
endmodule